// File: doc/BRIEF.md
# Preamble Detection Qualifier

This block sits behind a correlator in a packet receiver and decides whether a real preamble is on the air. Once per symbol period the correlator hands it a strobe with three results: the time index of the strongest correlation peak, the frequency index of that peak, and the peak magnitude. A dynamic base threshold arrives with it. A symbol takes part only if its frequency index is enabled in a mask and its magnitude beats a fractionally scaled copy of the base threshold. A sliding window of recent symbols is then checked. The time indices of the symbols used must fit inside a programmable span, and so must their frequency indices.

One rule is tolerant: any four of the last five symbols may qualify, so one corrupt symbol is allowed. The other rule is strict: all of the last four symbols must qualify. When the chosen rule passes, the preamble-detected flag rises. The block then waits a programmable number of symbol periods for a start-of-frame-found pulse from the symbol recovery logic. If the pulse arrives, the block reports lock. If it does not, the block drops the flag, clears its history and searches again.

Top module: `pq_detect`

## Requirements
- R1: A synchronous active-high `rst` clears `pre_det`, `locked` and `restart`, and empties the symbol history. After reset, a single qualifying symbol never raises `pre_det`.
- R2: With `cfg_mode` = 1 (strict), `pre_det` rises when the four most recent strobes all qualify. It is visible in the clock after the completing strobe, and never after only three symbols since reset or restart.
- R3: With `cfg_mode` = 0 (tolerant), `pre_det` rises when any four of the five most recent strobes qualify. At least five strobes must have been received since reset or restart, and two failing symbols among the five prevent detection.
- R4: For the symbols used, the maximum time index minus the minimum time index must not exceed `cfg_tspan` (6 bits, default 3). A span of exactly `cfg_tspan` passes.
- R5: For the symbols used, the maximum frequency index minus the minimum frequency index must not exceed `cfg_fspan` (4 bits, default 1).
- R6: A symbol qualifies on magnitude only if `sym_mag`·16 > `base_thr`·(16 + `cfg_scale`). This is the base threshold times 1 + s3/2 + s2/4 + s1/8 + s0/16, and the default `cfg_scale` = 8 gives 1.5. Equality fails.
- R7: Bit i of the 15-bit `cfg_fmask` enables frequency index i. A symbol whose frequency index is disabled, or equals 15, does not qualify.
- R8: After detection, once `cfg_limit` strobes (4 bits, default 8; a value of 0 acts as 1) arrive without `sfd_found`, `pre_det` falls in the clock after the last of those strobes. `restart` pulses high for exactly that one clock, and the history is emptied.
- R9: `sfd_found` while `pre_det` is high sets `locked` in the next clock. While locked, `pre_det` stays high, no timeout occurs, and both hold until reset. If `sfd_found` and a strobe coincide, `sfd_found` wins.
- R10: `sfd_found` while `pre_det` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | One-clock strobe per symbol period |
| sym_time | input | 6 | Time index of the largest correlation peak |
| sym_freq | input | 4 | Frequency index of that peak |
| sym_mag | input | 12 | Peak magnitude |
| base_thr | input | 12 | Dynamic base threshold |
| cfg_mode | input | 1 | 0: any 4 of 5, 1: all of 4 |
| cfg_tspan | input | 6 | Allowed time-index span |
| cfg_fspan | input | 4 | Allowed frequency-index span |
| cfg_scale | input | 4 | Threshold fraction bits s3..s0 |
| cfg_fmask | input | 15 | Frequency index enable mask |
| cfg_limit | input | 4 | Start-of-frame wait, in symbol periods |
| sfd_found | input | 1 | Start-of-frame delimiter found pulse |
| pre_det | output | 1 | Preamble detected |
| locked | output | 1 | Start of frame found after detection |
| restart | output | 1 | One-clock pulse when the wait times out |

## Verification
The bench targets the edges of each rule. It checks spans exactly equal to the limit and one above it, and magnitudes exactly at the scaled threshold and one count above, at scales 0, 8 and 15. A comparison off by one, or a threshold truncated before the compare, would then accept or reject the wrong symbol.

It separates the two window rules with one failing symbol: the tolerant rule must accept the window, and the strict rule must reject it until four clean symbols follow. A mixed-up rule would flag the wrong case. It counts the strobes in the start-of-frame wait one by one and then sends exactly three fresh symbols. If the history were not cleared on restart, a stale window would raise detection too early.

// File: rtl/pq_pkg.sv
package pq_pkg;
  // Controller states of the start-of-frame wait.
  typedef enum logic [1:0] {
    PQ_SEARCH = 2'd0,
    PQ_WAIT   = 2'd1,
    PQ_LOCK   = 2'd2
  } pq_state_e;

  // Number of symbol slots in the history window.
  localparam int PQ_WIN = 5;
  // Number of slots that must qualify in either rule.
  localparam int PQ_NEED = PQ_WIN - 1;
endpackage

// File: rtl/pq_sym_qual.sv
// Per-symbol qualification: frequency enable mask and scaled magnitude threshold.
module pq_sym_qual #(
  parameter int FREQ_W  = 4,
  parameter int MAG_W   = 12,
  parameter int SCALE_W = 4,
  localparam int NFREQ  = (1 << FREQ_W) - 1,
  localparam int PROD_W = MAG_W + SCALE_W + 1
) (
  input  logic [FREQ_W-1:0]  freq,
  input  logic [MAG_W-1:0]   mag,
  input  logic [MAG_W-1:0]   base,
  input  logic [SCALE_W-1:0] scale,
  input  logic [NFREQ-1:0]   fmask,
  output logic               freq_ok,
  output logic               mag_ok,
  output logic               qual
);
  // base * (2^SCALE_W + scale), built from shifts and adds only.
  function automatic logic [PROD_W-1:0] thr_x16(input logic [MAG_W-1:0] b,
                                                input logic [SCALE_W-1:0] s);
    logic [PROD_W-1:0] acc;
    acc = PROD_W'(b) << SCALE_W;
    for (int j = 0; j < SCALE_W; j++) begin
      if (s[j]) acc = acc + (PROD_W'(b) << j);
    end
    return acc;
  endfunction

  logic [PROD_W-1:0] mag_x;
  logic [PROD_W-1:0] thr_x;
  logic [NFREQ:0]    mask_ext;

  assign mag_x    = PROD_W'(mag) << SCALE_W;
  assign thr_x    = thr_x16(base, scale);
  assign mask_ext = {1'b0, fmask};
  assign freq_ok  = mask_ext[freq];
  assign mag_ok   = mag_x > thr_x;
  assign qual     = freq_ok && mag_ok;
endmodule

// File: rtl/pq_window.sv
// Symbol history and the two detection rules, evaluated on the window as it
// will look after the current strobe has been shifted in.
module pq_window
  import pq_pkg::*;
#(
  parameter int TIME_W   = 6,
  parameter int FREQ_W   = 4,
  parameter int TSPAN_W  = 6,
  parameter int FSPAN_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               push,
  input  logic [TIME_W-1:0]  in_time,
  input  logic [FREQ_W-1:0]  in_freq,
  input  logic               in_qual,
  input  logic               cfg_mode,
  input  logic [TSPAN_W-1:0] cfg_tspan,
  input  logic [FSPAN_W-1:0] cfg_fspan,
  output logic               hit,
  output logic [PQ_WIN-1:0]  sub_ok
);
  logic [TIME_W-1:0] h_time [PQ_WIN];
  logic [FREQ_W-1:0] h_freq [PQ_WIN];
  logic [PQ_WIN-1:0] h_qual;
  logic [PQ_WIN-1:0] h_val;

  logic [TIME_W-1:0] n_time [PQ_WIN];
  logic [FREQ_W-1:0] n_freq [PQ_WIN];
  logic [PQ_WIN-1:0] n_qual;
  logic [PQ_WIN-1:0] n_val;

  // Slot 0 is the newest symbol.
  always_comb begin
    n_time[0] = in_time;
    n_freq[0] = in_freq;
    n_qual[0] = in_qual;
    n_val[0]  = 1'b1;
    for (int i = 1; i < PQ_WIN; i++) begin
      n_time[i] = h_time[i-1];
      n_freq[i] = h_freq[i-1];
      n_qual[i] = h_qual[i-1];
      n_val[i]  = h_val[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      h_qual <= '0;
      h_val  <= '0;
      for (int i = 0; i < PQ_WIN; i++) begin
        h_time[i] <= '0;
        h_freq[i] <= '0;
      end
    end else if (push) begin
      h_qual <= n_qual;
      h_val  <= n_val;
      for (int i = 0; i < PQ_WIN; i++) begin
        h_time[i] <= n_time[i];
        h_freq[i] <= n_freq[i];
      end
    end
  end

  // One candidate subset per excluded slot; excluding the oldest slot gives
  // the four most recent symbols used by the strict rule.
  for (genvar k = 0; k < PQ_WIN; k++) begin : g_sub
    logic [TIME_W-1:0] tmin, tmax;
    logic [FREQ_W-1:0] fmin, fmax;
    logic              allq;
    always_comb begin
      tmin = '1;
      tmax = '0;
      fmin = '1;
      fmax = '0;
      allq = 1'b1;
      for (int i = 0; i < PQ_WIN; i++) begin
        if (i != k) begin
          if (n_time[i] < tmin) tmin = n_time[i];
          if (n_time[i] > tmax) tmax = n_time[i];
          if (n_freq[i] < fmin) fmin = n_freq[i];
          if (n_freq[i] > fmax) fmax = n_freq[i];
          allq = allq && n_qual[i];
        end
      end
      sub_ok[k] = allq
               && (int'(tmax - tmin) <= int'(cfg_tspan))
               && (int'(fmax - fmin) <= int'(cfg_fspan));
    end
  end

  logic four_val, five_val, rule_strict, rule_tol;
  assign four_val    = &n_val[PQ_NEED-1:0];
  assign five_val    = &n_val;
  assign rule_strict = four_val && sub_ok[PQ_WIN-1];
  assign rule_tol    = five_val && (|sub_ok);
  assign hit         = push && (cfg_mode ? rule_strict : rule_tol);
endmodule

// File: rtl/pq_sfd_timer.sv
// Detection flag, start-of-frame wait counter and lock state.
module pq_sfd_timer
  import pq_pkg::*;
#(
  parameter int LIM_W = 4,
  localparam int CNT_W = LIM_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic             sym_valid,
  input  logic             sfd_found,
  input  logic [LIM_W-1:0] cfg_limit,
  output logic             searching,
  output logic             timeout_evt,
  output logic             lock_evt,
  output logic [CNT_W-1:0] wait_cnt,
  output logic             pre_det,
  output logic             locked,
  output logic             restart
);
  pq_state_e        state;
  logic [CNT_W-1:0] eff_limit;
  logic [CNT_W-1:0] cnt_inc;

  assign eff_limit   = (cfg_limit == '0) ? CNT_W'(1) : CNT_W'(cfg_limit);
  assign cnt_inc     = wait_cnt + CNT_W'(1);
  assign searching   = (state == PQ_SEARCH);
  assign lock_evt    = (state == PQ_WAIT) && sfd_found;
  assign timeout_evt = (state == PQ_WAIT) && !sfd_found && sym_valid
                    && (cnt_inc >= eff_limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= PQ_SEARCH;
      wait_cnt <= '0;
      pre_det  <= 1'b0;
      locked   <= 1'b0;
      restart  <= 1'b0;
    end else begin
      restart <= 1'b0;
      case (state)
        PQ_SEARCH: begin
          if (hit) begin
            state    <= PQ_WAIT;
            wait_cnt <= '0;
            pre_det  <= 1'b1;
          end
        end
        PQ_WAIT: begin
          if (lock_evt) begin
            state  <= PQ_LOCK;
            locked <= 1'b1;
          end else if (timeout_evt) begin
            state    <= PQ_SEARCH;
            wait_cnt <= '0;
            pre_det  <= 1'b0;
            restart  <= 1'b1;
          end else if (sym_valid) begin
            wait_cnt <= cnt_inc;
          end
        end
        default: begin
          state <= PQ_LOCK;
        end
      endcase
    end
  end
endmodule

// File: rtl/pq_detect.sv
// Preamble detection qualifier top level.
module pq_detect
  import pq_pkg::*;
#(
  parameter int TIME_W  = 6,
  parameter int FREQ_W  = 4,
  parameter int MAG_W   = 12,
  parameter int SCALE_W = 4,
  parameter int TSPAN_W = 6,
  parameter int FSPAN_W = 4,
  parameter int LIM_W   = 4,
  localparam int NFREQ  = (1 << FREQ_W) - 1,
  localparam int CNT_W  = LIM_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sym_valid,
  input  logic [TIME_W-1:0]  sym_time,
  input  logic [FREQ_W-1:0]  sym_freq,
  input  logic [MAG_W-1:0]   sym_mag,
  input  logic [MAG_W-1:0]   base_thr,
  input  logic               cfg_mode,
  input  logic [TSPAN_W-1:0] cfg_tspan,
  input  logic [FSPAN_W-1:0] cfg_fspan,
  input  logic [SCALE_W-1:0] cfg_scale,
  input  logic [NFREQ-1:0]   cfg_fmask,
  input  logic [LIM_W-1:0]   cfg_limit,
  input  logic               sfd_found,
  output logic               pre_det,
  output logic               locked,
  output logic               restart
);
  logic             sym_qual, freq_ok, mag_ok;
  logic             push, hit, searching;
  logic             timeout_evt, lock_evt;
  logic [PQ_WIN-1:0] sub_ok;
  logic [CNT_W-1:0] wait_cnt;

  assign push = sym_valid && searching;

  pq_sym_qual #(
    .FREQ_W (FREQ_W),
    .MAG_W  (MAG_W),
    .SCALE_W(SCALE_W)
  ) u_qual (
    .freq   (sym_freq),
    .mag    (sym_mag),
    .base   (base_thr),
    .scale  (cfg_scale),
    .fmask  (cfg_fmask),
    .freq_ok(freq_ok),
    .mag_ok (mag_ok),
    .qual   (sym_qual)
  );

  pq_window #(
    .TIME_W (TIME_W),
    .FREQ_W (FREQ_W),
    .TSPAN_W(TSPAN_W),
    .FSPAN_W(FSPAN_W)
  ) u_win (
    .clk      (clk),
    .rst      (rst),
    .clr      (timeout_evt),
    .push     (push),
    .in_time  (sym_time),
    .in_freq  (sym_freq),
    .in_qual  (sym_qual),
    .cfg_mode (cfg_mode),
    .cfg_tspan(cfg_tspan),
    .cfg_fspan(cfg_fspan),
    .hit      (hit),
    .sub_ok   (sub_ok)
  );

  pq_sfd_timer #(
    .LIM_W(LIM_W)
  ) u_tmr (
    .clk        (clk),
    .rst        (rst),
    .hit        (hit),
    .sym_valid  (sym_valid),
    .sfd_found  (sfd_found),
    .cfg_limit  (cfg_limit),
    .searching  (searching),
    .timeout_evt(timeout_evt),
    .lock_evt   (lock_evt),
    .wait_cnt   (wait_cnt),
    .pre_det    (pre_det),
    .locked     (locked),
    .restart    (restart)
  );
endmodule

// File: rtl/pq_detect_chk.sv
module pq_detect_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             sym_valid,
  input logic             sfd_found,
  input logic             hit,
  input logic             searching,
  input logic             timeout_evt,
  input logic             lock_evt,
  input logic [CNT_W-1:0] wait_cnt,
  input logic             pre_det,
  input logic             locked,
  input logic             restart
);
  // R2
  det_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pre_det) |-> $past(sym_valid) && $past(hit));

  // R9
  lock_needs_det_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(sfd_found) && $past(pre_det));

  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked && pre_det);

  // R8
  restart_drops_det_chk: assert property (@(posedge clk) disable iff (rst)
    restart |-> !pre_det && $past(pre_det));

  // R8
  timeout_restart_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_evt |=> restart && searching);

  // R8
  restart_single_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> !restart);

  // R10
  no_lock_in_search_chk: assert property (@(posedge clk) disable iff (rst)
    searching |-> !lock_evt && !locked);

  // R8
  wait_cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    searching |-> wait_cnt == '0);
endmodule

bind pq_detect pq_detect_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sym_valid  (sym_valid),
  .sfd_found  (sfd_found),
  .hit        (hit),
  .searching  (searching),
  .timeout_evt(timeout_evt),
  .lock_evt   (lock_evt),
  .wait_cnt   (wait_cnt),
  .pre_det    (pre_det),
  .locked     (locked),
  .restart    (restart)
);

// File: tb/sim_pq_detect.sv
`timescale 1ns/1ps
module sim_pq_detect;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sym_valid = 1'b0;
  logic [5:0]  sym_time = '0;
  logic [3:0]  sym_freq = '0;
  logic [11:0] sym_mag = '0;
  logic [11:0] base_thr = 12'd100;
  logic        cfg_mode = 1'b1;
  logic [5:0]  cfg_tspan = 6'd3;
  logic [3:0]  cfg_fspan = 4'd1;
  logic [3:0]  cfg_scale = 4'd8;
  logic [14:0] cfg_fmask = '1;
  logic [3:0]  cfg_limit = 4'd8;
  logic        sfd_found = 1'b0;
  logic        pre_det, locked, restart;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pq_detect u0 (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_time(sym_time),
    .sym_freq(sym_freq), .sym_mag(sym_mag), .base_thr(base_thr),
    .cfg_mode(cfg_mode), .cfg_tspan(cfg_tspan), .cfg_fspan(cfg_fspan),
    .cfg_scale(cfg_scale), .cfg_fmask(cfg_fmask), .cfg_limit(cfg_limit),
    .sfd_found(sfd_found), .pre_det(pre_det), .locked(locked),
    .restart(restart)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    sym_valid = 1'b0; sfd_found = 1'b0;
    base_thr = 12'd100; cfg_mode = 1'b1; cfg_tspan = 6'd3; cfg_fspan = 4'd1;
    cfg_scale = 4'd8; cfg_fmask = '1; cfg_limit = 4'd8;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Drive one strobe; returns at the negedge after the sampling edge.
  task automatic send(input int t, input int f, input int m);
    sym_time = 6'(t); sym_freq = 4'(f); sym_mag = 12'(m);
    sym_valid = 1'b1;
    @(negedge clk);
    sym_valid = 1'b0;
  endtask

  task automatic good(); send(20, 5, 200); endtask
  task automatic bad();  send(20, 5, 50);  endtask

  task automatic pulse_sfd();
    sfd_found = 1'b1;
    @(negedge clk);
    sfd_found = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 pre_det after reset", pre_det, 0);
    chk("R1 locked after reset", locked, 0);
    chk("R1 restart after reset", restart, 0);
    good(); good(); good();
    do_reset();
    good();
    chk("R1 history emptied by reset", pre_det, 0);
  endtask

  task automatic t_strict();
    do_reset();
    good(); chk("R2 one symbol", pre_det, 0);
    good(); chk("R2 two symbols", pre_det, 0);
    good(); chk("R2 three symbols", pre_det, 0);
    good(); chk("R2 four symbols", pre_det, 1);
  endtask

  task automatic t_tolerant();
    do_reset(); cfg_mode = 1'b0;
    good(); bad(); good(); good();
    chk("R3 only four symbols", pre_det, 0);
    good();
    chk("R3 four of five", pre_det, 1);
    do_reset(); cfg_mode = 1'b1;
    good(); bad(); good(); good(); good();
    chk("R2 strict rejects one bad", pre_det, 0);
    good();
    chk("R2 strict four clean", pre_det, 1);
    do_reset(); cfg_mode = 1'b0;
    good(); bad(); good(); bad(); good(); good();
    chk("R3 two bad in five", pre_det, 0);
  endtask

  task automatic t_tspan();
    do_reset();
    send(10,5,200); send(11,5,200); send(12,5,200); send(13,5,200);
    chk("R4 span equal limit", pre_det, 1);
    do_reset();
    send(10,5,200); send(11,5,200); send(12,5,200); send(14,5,200);
    chk("R4 span above limit", pre_det, 0);
    do_reset(); cfg_tspan = 6'd0;
    send(7,5,200); send(7,5,200); send(7,5,200); send(7,5,200);
    chk("R4 zero span equal times", pre_det, 1);
  endtask

  task automatic t_fspan();
    do_reset();
    send(20,2,200); send(20,3,200); send(20,2,200); send(20,3,200);
    chk("R5 freq span 1", pre_det, 1);
    do_reset();
    send(20,2,200); send(20,4,200); send(20,2,200); send(20,4,200);
    chk("R5 freq span 2 limit 1", pre_det, 0);
    do_reset(); cfg_fspan = 4'd2;
    send(20,2,200); send(20,4,200); send(20,2,200); send(20,4,200);
    chk("R5 freq span 2 limit 2", pre_det, 1);
  endtask

  task automatic thr_case(input int s, input int m);
    int exp;
    do_reset(); cfg_scale = 4'(s);
    exp = (m * 16 > 100 * (16 + s)) ? 1 : 0;
    for (int i = 0; i < 4; i++) send(20, 5, m);
    chk($sformatf("R6 scale %0d mag %0d", s, m), pre_det, exp);
  endtask

  task automatic t_thresh();
    thr_case(8, 150); thr_case(8, 151);
    thr_case(15, 193); thr_case(15, 194);
    thr_case(0, 100); thr_case(0, 101);
  endtask

  task automatic t_mask();
    do_reset(); cfg_fmask = 15'h7FDF;
    for (int i = 0; i < 4; i++) send(20, 5, 200);
    chk("R7 masked index", pre_det, 0);
    do_reset();
    for (int i = 0; i < 4; i++) send(20, 14, 200);
    chk("R7 top index enabled", pre_det, 1);
    do_reset();
    for (int i = 0; i < 4; i++) send(20, 15, 200);
    chk("R7 index 15 never", pre_det, 0);
  endtask

  task automatic t_timeout();
    do_reset(); cfg_limit = 4'd3;
    good(); good(); good(); good();
    chk("R8 detected", pre_det, 1);
    good(); chk("R8 wait 1", pre_det, 1);
    good(); chk("R8 wait 2", pre_det, 1);
    chk("R8 no restart yet", restart, 0);
    good(); chk("R8 timeout drops", pre_det, 0);
    chk("R8 restart pulse", restart, 1);
    @(negedge clk);
    chk("R8 restart one clock", restart, 0);
    good(); good(); good();
    chk("R8 history emptied", pre_det, 0);
    good();
    chk("R8 search resumes", pre_det, 1);
    do_reset(); cfg_limit = 4'd0;
    good(); good(); good(); good();
    good();
    chk("R8 limit zero acts as one", pre_det, 0);
  endtask

  task automatic t_lock();
    do_reset(); cfg_limit = 4'd2;
    good(); good(); good(); good();
    good();
    pulse_sfd();
    chk("R9 locked", locked, 1);
    chk("R9 det held", pre_det, 1);
    for (int i = 0; i < 6; i++) good();
    chk("R9 no timeout while locked", pre_det, 1);
    chk("R9 still locked", locked, 1);
    chk("R9 no restart", restart, 0);
    do_reset(); cfg_limit = 4'd1;
    good(); good(); good(); good();
    sfd_found = 1'b1;
    good();
    sfd_found = 1'b0;
    chk("R9 sfd beats strobe", locked, 1);
    chk("R9 det kept on tie", pre_det, 1);
  endtask

  task automatic t_sfd_idle();
    do_reset();
    pulse_sfd();
    chk("R10 sfd in search locked", locked, 0);
    chk("R10 sfd in search det", pre_det, 0);
    good(); good(); good(); good();
    chk("R10 detection unaffected", pre_det, 1);
    chk("R10 not locked", locked, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_strict();
    t_tolerant();
    t_tspan();
    t_fspan();
    t_thresh();
    t_mask();
    t_timeout();
    t_lock();
    t_sfd_idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule